// File: doc/BRIEF.md
# Serial Transmitter with Priority Control-Character Slot

This block is the transmit side of an asynchronous serial port. Ordinary payload bytes arrive on a valid/ready stream and pass through a small character queue into a serializer, which sends each byte as a start bit, eight data bits (least significant first) and a stop bit. One bit goes out for each pulse on a bit-rate strobe that is generated outside the block.

Alongside the stream there is one software-written slot for a single urgent character, typically a flow-control byte such as XON or XOFF. The slot is examined whenever the transmitter is enabled. Once armed, its byte enters the queue ahead of any payload byte not yet accepted. It never displaces bytes already in the queue, and it is sent even while payload intake is frozen or no payload is offered. The slot reports when its character has gone out. It can raise a transmit event pulse, and it records whether clear-to-send dropped during that character. Queue depth can be cut to one entry to shorten the wait of the urgent character.

Top module: `ctl_char_uart_tx`

## Requirements
- R1: The line idles high. Each character is a low start bit, eight data bits least significant first, and a high stop bit. The serializer advances one bit per cycle in which `bit_tick_i` is high.
- R2: Payload bytes accepted on the stream (a cycle with `buf_valid_i` and `buf_ready_o` both high) are transmitted in acceptance order.
- R3: An armed slot character is loaded into the queue before any payload byte not yet accepted. It is sent after all bytes already in the queue, and it is loaded exactly once per arming.
- R4: A write with `oos_wr_arm_i`=1 while the slot is idle sets `oos_ready_o`. It stays 1 through the transmission and drops in the cycle after the slot character's stop bit completes.
- R5: While `freeze_i` is 1, `buf_ready_o` is 0 and no payload byte enters the queue, but an armed slot character is still loaded and sent. With no payload offered, an armed slot character is also sent.
- R6: While `tx_en_i` is 0, nothing enters the queue: `buf_ready_o` is 0 and an armed slot character waits with `oos_ready_o` held at 1.
- R7: A slot write while `oos_ready_o` is 1 is ignored entirely: character, interrupt-enable and ready are unchanged. A write while idle updates `oos_char_o` and `oos_ie_o`.
- R8: Queue capacity is 1 entry when `depth_one_i` is 1 and `FIFO_DEPTH` (default 4) when it is 0. The select is sampled only while `tx_en_i` is 0; changes made while enabled have no effect.
- R9: When the slot character completes, `tx_event_o` pulses high for exactly one cycle (the first cycle with `oos_ready_o` low) if the slot's interrupt-enable bit was 1, and stays low otherwise.
- R10: If `cts_mon_en_i` is 1 and `cts_i` is 0 in any cycle while the slot character is being shifted out, `oos_cts_lost_o` becomes 1 at completion. It is cleared by the next arming. With `cts_mon_en_i` at 0 it stays 0.
- R11: When R10 records a lost CTS and `buf_valid_i` is 1 at the slot character's completion, `buf_cts_lost_o` pulses for one cycle together with `tx_event_o` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmitter enable |
| freeze_i | input | 1 | Hold back payload intake |
| depth_one_i | input | 1 | 1 selects a single-entry queue |
| cts_mon_en_i | input | 1 | Enable clear-to-send monitoring |
| cts_i | input | 1 | Clear-to-send, 1 = asserted |
| bit_tick_i | input | 1 | Bit-rate strobe |
| buf_valid_i | input | 1 | Payload byte offered |
| buf_data_i | input | 8 | Payload byte |
| buf_ready_o | output | 1 | Payload byte accepted this cycle if valid |
| oos_wr_i | input | 1 | Slot write strobe |
| oos_wr_char_i | input | 8 | Slot character to write |
| oos_wr_arm_i | input | 1 | Arm the slot with this write |
| oos_wr_ie_i | input | 1 | Slot interrupt-enable to write |
| oos_char_o | output | 8 | Current slot character |
| oos_ready_o | output | 1 | Slot armed or in flight |
| oos_ie_o | output | 1 | Slot interrupt-enable |
| oos_cts_lost_o | output | 1 | CTS dropped during last slot character |
| tx_event_o | output | 1 | Slot completion event pulse |
| buf_cts_lost_o | output | 1 | CTS lost during slot character while payload pending |
| txd_o | output | 1 | Serial output line |

## Verification
The hardest situation to reach is a slot character that waits behind a completely full queue while payload keeps flowing. The stimulus holds the payload stream valid from the moment of enabling, so the queue fills within five cycles, and only then arms the slot. The expected byte order is then exact. CTS loss during a slot character that coincides with pending payload is reached by freezing intake with bytes still offered, pulling CTS low and arming the slot. That way `buf_valid_i` is known to be high at completion. A long random phase mixes freezes, gaps and arming against order checks on both byte classes.

// File: rtl/ctl_tx_pkg.sv
package ctl_tx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              is_ctl;
        logic [CHAR_W-1:0] chr;
    } tx_ent_t;
endpackage

// File: rtl/ctl_tx_fifo.sv
module ctl_tx_fifo
    import ctl_tx_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  tx_ent_t          push_ent_i,
    input  logic             pop_i,
    input  logic [CNT_W-1:0] lim_i,
    output tx_ent_t          head_o,
    output logic             empty_o,
    output logic             space_o
);
    typedef struct packed {
        tx_ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]    rd;
        logic [PTR_W-1:0]    wr;
        logic [CNT_W-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            s_d.mem[s_q.wr] = push_ent_i;
            s_d.wr          = ptr_inc(s_q.wr);
        end
        if (pop_i) begin
            s_d.rd = ptr_inc(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rd];
    assign empty_o = (s_q.cnt == '0);
    assign space_o = (s_q.cnt < lim_i);

    // R8: the loader never writes beyond the selected capacity
    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (s_q.cnt < lim_i));

    // R2: the serializer never takes from an empty queue
    assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (s_q.cnt != '0));
endmodule

// File: rtl/ctl_tx_shifter.sv
module ctl_tx_shifter
    import ctl_tx_pkg::*;
#(
    localparam int FRAME_W = CHAR_W + 2,
    localparam int BC_W    = $clog2(FRAME_W + 1)
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    tick_i,
    input  logic    load_i,
    input  tx_ent_t load_ent_i,
    output logic    busy_o,
    output logic    is_ctl_o,
    output logic    done_o,
    output logic    txd_o
);
    typedef struct packed {
        logic               busy;
        logic               is_ctl;
        logic [FRAME_W-1:0] sreg;
        logic [BC_W-1:0]    left;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic   done_c;

    always_comb begin
        s_d    = s_q;
        done_c = 1'b0;
        if (!s_q.busy) begin
            if (load_i) begin
                s_d.busy   = 1'b1;
                s_d.is_ctl = load_ent_i.is_ctl;
                s_d.sreg   = {1'b1, load_ent_i.chr, 1'b0};
                s_d.left   = BC_W'(FRAME_W);
            end
        end else if (tick_i) begin
            s_d.sreg = {1'b1, s_q.sreg[FRAME_W-1:1]};
            s_d.left = s_q.left - 1'b1;
            if (s_q.left == BC_W'(1)) begin
                s_d.busy = 1'b0;
                done_c   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{busy: 1'b0, is_ctl: 1'b0, sreg: '1, left: '0};
        else         s_q <= s_d;
    end

    assign busy_o   = s_q.busy;
    assign is_ctl_o = s_q.is_ctl;
    assign done_o   = done_c;
    assign txd_o    = s_q.busy ? s_q.sreg[0] : 1'b1;

    // R1: a frame opens with a low start bit
    assert_start_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.busy) |-> !txd_o);

    // R1: the last bit of a frame is the high stop bit
    assert_stop_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_c |-> txd_o);
endmodule

// File: rtl/ctl_tx_oos_reg.sv
module ctl_tx_oos_reg
    import ctl_tx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [CHAR_W-1:0] wr_char_i,
    input  logic              wr_arm_i,
    input  logic              wr_ie_i,
    input  logic              push_ctl_i,
    input  logic              done_ctl_i,
    input  logic              cts_bad_i,
    input  logic              buf_valid_i,
    output logic [CHAR_W-1:0] chr_o,
    output logic              ready_o,
    output logic              ie_o,
    output logic              lost_o,
    output logic              pending_o,
    output logic              event_o,
    output logic              bufct_o
);
    typedef struct packed {
        logic              ready;
        logic              queued;
        logic              ie;
        logic              lost;
        logic              acc;
        logic              ev;
        logic              bct;
        logic [CHAR_W-1:0] chr;
    } oos_st_t;

    oos_st_t s_d, s_q;
    logic    lost_now;

    always_comb begin
        s_d      = s_q;
        s_d.ev   = 1'b0;
        s_d.bct  = 1'b0;
        lost_now = s_q.acc | cts_bad_i;
        if (cts_bad_i)  s_d.acc    = 1'b1;
        if (push_ctl_i) s_d.queued = 1'b1;
        if (done_ctl_i) begin
            s_d.ready  = 1'b0;
            s_d.queued = 1'b0;
            s_d.lost   = lost_now;
            s_d.acc    = 1'b0;
            s_d.ev     = s_q.ie;
            s_d.bct    = lost_now & buf_valid_i;
        end else if (wr_i && !s_q.ready) begin
            s_d.chr = wr_char_i;
            s_d.ie  = wr_ie_i;
            if (wr_arm_i) begin
                s_d.ready = 1'b1;
                s_d.lost  = 1'b0;
                s_d.acc   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign chr_o     = s_q.chr;
    assign ready_o   = s_q.ready;
    assign ie_o      = s_q.ie;
    assign lost_o    = s_q.lost;
    assign pending_o = s_q.ready & ~s_q.queued;
    assign event_o   = s_q.ev;
    assign bufct_o   = s_q.bct;

    // R4: ready holds until the slot character completes
    assert_ready_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ready && !done_ctl_i |=> s_q.ready);

    // R7: the character cannot change while armed
    assert_char_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ready |=> $stable(s_q.chr));

    // R9: the event is a single-cycle pulse
    assert_event_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ev |=> !s_q.ev);

    // R9: the event coincides with the end of the armed period
    assert_event_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.ev) |-> $fell(s_q.ready));

    // R11: a pending-payload CTS report implies the slot recorded the loss
    assert_bufct_implies_lost_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.bct |-> s_q.lost);
endmodule

// File: rtl/ctl_char_uart_tx.sv
module ctl_char_uart_tx
    import ctl_tx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 4,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_en_i,
    input  logic              freeze_i,
    input  logic              depth_one_i,
    input  logic              cts_mon_en_i,
    input  logic              cts_i,
    input  logic              bit_tick_i,
    input  logic              buf_valid_i,
    input  logic [CHAR_W-1:0] buf_data_i,
    output logic              buf_ready_o,
    input  logic              oos_wr_i,
    input  logic [CHAR_W-1:0] oos_wr_char_i,
    input  logic              oos_wr_arm_i,
    input  logic              oos_wr_ie_i,
    output logic [CHAR_W-1:0] oos_char_o,
    output logic              oos_ready_o,
    output logic              oos_ie_o,
    output logic              oos_cts_lost_o,
    output logic              tx_event_o,
    output logic              buf_cts_lost_o,
    output logic              txd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lim;
    } top_st_t;

    top_st_t st_d, st_q;

    tx_ent_t push_ent, head_ent;
    logic    fifo_push, fifo_pop, fifo_empty, fifo_space;
    logic    can_load, push_ctl, oos_pending;
    logic    sh_busy, sh_is_ctl, sh_done, done_ctl, cts_bad;

    // capacity follows the select only while disabled
    always_comb begin
        st_d = st_q;
        if (!tx_en_i) begin
            st_d.lim = depth_one_i ? CNT_W'(1) : CNT_W'(FIFO_DEPTH);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{lim: CNT_W'(FIFO_DEPTH)};
        else         st_q <= st_d;
    end

    // loader: slot character wins the free queue entry over payload
    always_comb begin
        can_load    = tx_en_i & fifo_space;
        push_ctl    = can_load & oos_pending;
        buf_ready_o = can_load & ~oos_pending & ~freeze_i;
        fifo_push   = push_ctl | (buf_ready_o & buf_valid_i);
        if (push_ctl) push_ent = '{is_ctl: 1'b1, chr: oos_char_o};
        else          push_ent = '{is_ctl: 1'b0, chr: buf_data_i};
        fifo_pop    = tx_en_i & ~sh_busy & ~fifo_empty;
        done_ctl    = sh_done & sh_is_ctl;
        cts_bad     = cts_mon_en_i & ~cts_i & sh_busy & sh_is_ctl;
    end

    ctl_tx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (fifo_push),
        .push_ent_i (push_ent),
        .pop_i      (fifo_pop),
        .lim_i      (st_q.lim),
        .head_o     (head_ent),
        .empty_o    (fifo_empty),
        .space_o    (fifo_space)
    );

    ctl_tx_shifter i_shifter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (bit_tick_i),
        .load_i     (fifo_pop),
        .load_ent_i (head_ent),
        .busy_o     (sh_busy),
        .is_ctl_o   (sh_is_ctl),
        .done_o     (sh_done),
        .txd_o      (txd_o)
    );

    ctl_tx_oos_reg i_oos (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (oos_wr_i),
        .wr_char_i   (oos_wr_char_i),
        .wr_arm_i    (oos_wr_arm_i),
        .wr_ie_i     (oos_wr_ie_i),
        .push_ctl_i  (push_ctl),
        .done_ctl_i  (done_ctl),
        .cts_bad_i   (cts_bad),
        .buf_valid_i (buf_valid_i),
        .chr_o       (oos_char_o),
        .ready_o     (oos_ready_o),
        .ie_o        (oos_ie_o),
        .lost_o      (oos_cts_lost_o),
        .pending_o   (oos_pending),
        .event_o     (tx_event_o),
        .bufct_o     (buf_cts_lost_o)
    );

    // R3: one arming loads the slot character only once
    assert_ctl_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_ctl |=> !oos_pending);

    // R5: while frozen only the slot character may enter the queue
    assert_freeze_only_ctl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_i && fifo_push |-> push_ent.is_ctl);

    // R6: a disabled transmitter loads nothing
    assert_disabled_no_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_en_i |-> !fifo_push);

    // R8: capacity is frozen while enabled
    assert_depth_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_en_i && $past(tx_en_i) |-> $stable(st_q.lim));
endmodule

// File: tb/test_ctl_char_uart_tx.sv
`timescale 1ns/1ps
module test_ctl_char_uart_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, freeze = 1'b0, depth_one = 1'b0;
    logic cts_mon_en = 1'b0, cts = 1'b1, bit_tick = 1'b1;
    logic buf_valid = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic buf_ready;
    logic oos_wr = 1'b0, oos_wr_arm = 1'b0, oos_wr_ie = 1'b0;
    logic [7:0] oos_wr_char = 8'h00;
    logic [7:0] oos_char;
    logic oos_ready, oos_ie, oos_cts_lost, tx_event, buf_cts_lost, txd;

    int checks = 0, failures = 0;
    int ev_cnt = 0, bct_cnt = 0, frame_err = 0;
    int gap_pct = 0;
    logic fire = 1'b0;
    logic [7:0] feed_q[$], acc_q[$], rx_q[$], want_q[$], inj_q[$];
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    ctl_char_uart_tx i_ctl_char_uart_tx (
        .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .freeze_i(freeze),
        .depth_one_i(depth_one), .cts_mon_en_i(cts_mon_en), .cts_i(cts),
        .bit_tick_i(bit_tick), .buf_valid_i(buf_valid), .buf_data_i(buf_data),
        .buf_ready_o(buf_ready), .oos_wr_i(oos_wr), .oos_wr_char_i(oos_wr_char),
        .oos_wr_arm_i(oos_wr_arm), .oos_wr_ie_i(oos_wr_ie), .oos_char_o(oos_char),
        .oos_ready_o(oos_ready), .oos_ie_o(oos_ie), .oos_cts_lost_o(oos_cts_lost),
        .tx_event_o(tx_event), .buf_cts_lost_o(buf_cts_lost), .txd_o(txd)
    );

    // payload feeder
    always @(negedge clk) begin
        if (fire) begin
            acc_q.push_back(buf_data);
            void'(feed_q.pop_front());
        end
        if (feed_q.size() != 0 && ($urandom_range(99) >= gap_pct)) begin
            buf_valid = 1'b1;
            buf_data  = feed_q[0];
        end else begin
            buf_valid = 1'b0;
        end
        #1;
        fire = buf_valid && buf_ready;
    end

    // line decoder and pulse counters
    int dbit = 0;
    logic dfr = 1'b0;
    logic [7:0] dsh = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_event)     ev_cnt++;
            if (buf_cts_lost) bct_cnt++;
            if (!dfr) begin
                if (txd === 1'b0) begin dfr = 1'b1; dbit = 0; end
            end else if (dbit < 8) begin
                dsh[dbit] = txd;
                dbit++;
            end else begin
                if (txd !== 1'b1) frame_err++;
                rx_q.push_back(dsh);
                dfr = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slot_write(input logic [7:0] ch, input logic arm, input logic ie);
        @(negedge clk);
        oos_wr = 1'b1; oos_wr_char = ch; oos_wr_arm = arm; oos_wr_ie = ie;
        @(negedge clk);
        oos_wr = 1'b0; oos_wr_arm = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((feed_q.size() != 0 || oos_ready || buf_valid) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        cyc(80);
    endtask

    task automatic clear_logs();
        acc_q.delete(); rx_q.delete(); want_q.delete();
    endtask

    task automatic chk_seq(input string tag);
        int bad = -1;
        if (rx_q.size() == want_q.size()) begin
            foreach (want_q[i]) if (bad < 0 && rx_q[i] != want_q[i]) bad = i;
        end else begin
            bad = 0;
        end
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else if (rx_q.size() != want_q.size()) chk(1'b0, {tag, " count"}, rx_q.size(), want_q.size());
        else chk(1'b0, tag, rx_q[bad], want_q[bad]);
    endtask

    function automatic logic [7:0] ord(input logic [7:0] base, input int k);
        return base + 8'(k);
    endfunction

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        int ev0, b0, ie_arms;
        logic [7:0] bq[$], iq[$];
        void'($urandom(32'd7321));
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // reset state (R1, R6, R4)
        chk(txd == 1'b1, "R1 idle line after reset", txd, 1);
        chk(oos_ready == 1'b0, "R4 ready after reset", oos_ready, 0);
        chk(buf_ready == 1'b0, "R6 no intake while disabled", buf_ready, 0);

        // R1, R2: plain payload
        depth_one = 1'b0; cyc(1);
        tx_en = 1'b1;
        feed_q.push_back(8'h35); feed_q.push_back(8'h5A); feed_q.push_back(8'h01);
        drain();
        want_q = '{8'h35, 8'h5A, 8'h01};
        chk_seq("R2 payload order");
        chk(frame_err == 0, "R1 stop bits", frame_err, 0);

        // R3, R8, R6: slot behind a full 4-entry queue; select change while enabled ignored
        tx_en = 1'b0; clear_logs(); cyc(2);
        for (int k = 0; k < 8; k++) feed_q.push_back(ord(8'h10, k));
        cyc(4);
        chk(acc_q.size() == 0, "R6 nothing accepted while disabled", acc_q.size(), 0);
        tx_en = 1'b1;
        cyc(6);
        depth_one = 1'b1;
        ev0 = ev_cnt;
        slot_write(8'hA0, 1'b1, 1'b1);
        drain();
        want_q = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'hA0, 8'h15, 8'h16, 8'h17};
        chk_seq("R3 R8 slot after full queue of four");
        chk(ev_cnt - ev0 == 1, "R9 event with ie set", ev_cnt - ev0, 1);
        chk(oos_ready == 1'b0, "R4 ready cleared after send", oos_ready, 0);

        // R8: single-entry queue
        tx_en = 1'b0; clear_logs(); cyc(2);
        for (int k = 0; k < 6; k++) feed_q.push_back(ord(8'h20, k));
        tx_en = 1'b1;
        cyc(6);
        ev0 = ev_cnt;
        slot_write(8'hA1, 1'b1, 1'b0);
        drain();
        want_q = '{8'h20, 8'h21, 8'hA1, 8'h22, 8'h23, 8'h24, 8'h25};
        chk_seq("R8 slot after single-entry queue");
        chk(ev_cnt == ev0, "R9 no event with ie clear", ev_cnt - ev0, 0);

        // R5: freeze blocks payload but not the slot
        tx_en = 1'b0; depth_one = 1'b0; clear_logs(); cyc(2);
        tx_en = 1'b1; freeze = 1'b1;
        feed_q.push_back(8'h30); feed_q.push_back(8'h31);
        cyc(20);
        chk(acc_q.size() == 0, "R5 no payload accepted while frozen", acc_q.size(), 0);
        chk(buf_ready == 1'b0, "R5 ready low while frozen", buf_ready, 0);
        slot_write(8'hA2, 1'b1, 1'b0);
        cyc(40);
        want_q = '{8'hA2};
        chk_seq("R5 slot sent while frozen");
        chk(oos_ready == 1'b0, "R4 ready cleared while frozen", oos_ready, 0);
        freeze = 1'b0;
        drain();
        want_q = '{8'hA2, 8'h30, 8'h31};
        chk_seq("R5 payload resumes after freeze");

        // R5: slot with no payload offered
        clear_logs();
        slot_write(8'hA3, 1'b1, 1'b0);
        drain();
        want_q = '{8'hA3};
        chk_seq("R5 slot with no payload");

        // R6, R7: armed while disabled; writes while armed ignored
        tx_en = 1'b0; clear_logs(); ev0 = ev_cnt;
        slot_write(8'hA4, 1'b1, 1'b0);
        slot_write(8'h55, 1'b0, 1'b1);
        cyc(30);
        chk(oos_char == 8'hA4, "R7 char kept while armed", oos_char, 8'hA4);
        chk(oos_ie == 1'b0, "R7 ie kept while armed", oos_ie, 0);
        chk(oos_ready == 1'b1, "R6 armed slot waits while disabled", oos_ready, 1);
        chk(rx_q.size() == 0, "R6 nothing sent while disabled", rx_q.size(), 0);
        tx_en = 1'b1;
        drain();
        want_q = '{8'hA4};
        chk_seq("R7 original char sent");
        chk(ev_cnt == ev0, "R7 ignored ie write has no event", ev_cnt - ev0, 0);
        slot_write(8'h66, 1'b0, 1'b0);
        cyc(1);
        chk(oos_char == 8'h66 && oos_ready == 1'b0, "R7 idle write updates char", oos_char, 8'h66);

        // R10: CTS lost with no payload pending
        clear_logs(); cts_mon_en = 1'b1; cts = 1'b0; b0 = bct_cnt;
        slot_write(8'hA5, 1'b1, 1'b0);
        drain();
        chk(oos_cts_lost == 1'b1, "R10 cts loss recorded", oos_cts_lost, 1);
        chk(bct_cnt == b0, "R11 no payload report without pending data", bct_cnt - b0, 0);

        // R11: CTS lost while payload is pending (frozen with data offered)
        clear_logs(); freeze = 1'b1;
        feed_q.push_back(8'h41); feed_q.push_back(8'h42);
        cyc(3);
        slot_write(8'hA6, 1'b1, 1'b1);
        cyc(40);
        chk(bct_cnt - b0 == 1, "R11 payload cts report", bct_cnt - b0, 1);
        chk(oos_cts_lost == 1'b1, "R10 cts loss during frozen send", oos_cts_lost, 1);
        freeze = 1'b0; cts = 1'b1;
        drain();

        // R10: monitoring disabled, and re-arm clears the flag
        cts_mon_en = 1'b0; cts = 1'b0;
        slot_write(8'hA7, 1'b1, 1'b0);
        cyc(1);
        chk(oos_cts_lost == 1'b0, "R10 re-arm clears cts lost", oos_cts_lost, 0);
        drain();
        chk(oos_cts_lost == 1'b0, "R10 no loss with monitoring off", oos_cts_lost, 1'b0);
        cts = 1'b1;

        // random mix: payload bytes have bit 7 clear, slot bytes have bit 7 set
        tx_en = 1'b0; depth_one = 1'($urandom_range(1)); cyc(2);
        clear_logs(); inj_q.delete();
        tx_en = 1'b1; gap_pct = 30; ev0 = ev_cnt; ie_arms = 0;
        for (int k = 0; k < 300; k++) feed_q.push_back(8'($urandom_range(127)));
        for (int c = 0; c < 6000; c++) begin
            logic [7:0] ch;
            logic ie;
            @(negedge clk);
            oos_wr = 1'b0; oos_wr_arm = 1'b0;
            if ($urandom_range(99) < 4) freeze = ~freeze;
            if (!oos_ready && $urandom_range(99) < 2) begin
                ch = 8'h80 | 8'($urandom_range(127));
                ie = 1'($urandom_range(1));
                oos_wr = 1'b1; oos_wr_arm = 1'b1; oos_wr_char = ch; oos_wr_ie = ie;
                inj_q.push_back(ch);
                if (ie) ie_arms++;
            end
        end
        @(negedge clk);
        oos_wr = 1'b0; oos_wr_arm = 1'b0; freeze = 1'b0;
        drain();
        foreach (rx_q[i]) begin
            if (rx_q[i][7]) iq.push_back(rx_q[i]);
            else            bq.push_back(rx_q[i]);
        end
        rx_q = bq; want_q = acc_q;
        chk_seq("R2 random payload order");
        rx_q = iq; want_q = inj_q;
        chk_seq("R3 random slot characters");
        chk(ev_cnt - ev0 == ie_arms, "R9 random event count", ev_cnt - ev0, ie_arms);
        chk(frame_err == 0, "R1 random stop bits", frame_err, 0);

        done_flag = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule